// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Slice

This block is the local interrupt state held for one processor. It stores fifteen software interrupt bits, a broadcast level-15 bit and a private timer bit. From the system-level controller it receives three things: a 16-bit vector of hard interrupt levels already steered and masked for this processor, an unmasked copy of those levels for display, and a global master-disable flag. It merges these into a registered per-level request vector for levels 1 to 15. It also produces a registered 4-bit code naming the highest requesting level.

Software reaches the slice through a word-addressed 32-bit register port with a 2-bit word select (address bits [3:2] of a 16-byte window). Word 0 reads the pending register. Word 1 is a write-one-to-clear port and word 2 is a write-one-to-set port for the software bits. Read data comes back one cycle after the read strobe. Writes land on the clock edge that samples the write strobe.

Top module: `cpu_irq_slice`

## Requirements
- R1: After reset the pending register, the read data, the request vector and the level code are all zero.
- R2: A read strobe with word select 0 returns the pending view one cycle later; with any other select it returns zero; without a strobe the read data holds its value.
- R3: A write to word 1 clears each pending bit whose data bit is 1, but only among bits 31..17 and bit 15; all other bits are unaffected.
- R4: A write to word 2 sets each pending bit whose data bit is 1, but only among bits 31..17; writes to words 0 and 3 change nothing.
- R5: Pending bit 14 takes the value of the timer input one cycle later and cannot be written by software.
- R6: Pending bit 15 is set by a rising edge and cleared by a falling edge of the level-15 input; when a rising edge and a word-1 clear of bit 15 fall in the same cycle, the bit ends up set.
- R7: In the read view, bits 13..1 show the unmasked hard levels 13..1 while the target flag is high and zero otherwise; bits 16 and 0 always read zero.
- R8: One cycle after any change, the request vector equals the hard request vector (bit 0 dropped), ORed with pending bits 15 and 14 at the same positions, ORed with pending bits 31..17 placed on levels 15..1 (pending bit k drives level k-16); bit 0 is always zero.
- R9: The level code equals the index of the highest set bit of the request vector, or 0 when no bit is set, and changes in the same cycle as the vector.
- R10: While master-disable is high, pending bits 15 and 14 do not reach the request vector, while software bits and hard levels still do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_sel | input | 2 | Word select, address bits [3:2] |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| timer_in | input | 1 | Private timer interrupt level |
| lvl15_in | input | 1 | Broadcast level-15 interrupt level |
| hard_req | input | 16 | Hard levels steered and masked for this CPU |
| hard_raw | input | 16 | Hard levels pending regardless of per-source mask |
| is_target | input | 1 | This CPU is the current hard-interrupt target |
| master_dis | input | 1 | Global master-disable flag |
| req_lvl | output | 16 | Registered per-level request vector |
| irl | output | 4 | Registered highest requesting level |

## Verification
The collision that matters here is a level-15 edge and a software clear of bit 15 landing on the same clock edge. The bench provokes it on purpose by raising the level-15 input in the same cycle as a word-1 write with bit 15 set. It then judges the read view and the request vector against a model in which the edge wins. The random phase also lets timer and level-15 changes coincide with set and clear writes, and compares every output each cycle.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;

  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_CLR  = 2'd1,
    SEL_SET  = 2'd2,
    SEL_NONE = 2'd3
  } word_sel_e;

endpackage

// File: rtl/irq_pend_regs.sv
module irq_pend_regs
  import cpu_irq_pkg::*;
#(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned WORD_W = 2 * LVL_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        word_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              timer_in,
  input  logic              lvl15_in,
  output logic [WORD_W-1:0] pend_q
);

  localparam int unsigned SOFT_LO = LVL_N + 1;
  localparam int unsigned SOFT_N  = WORD_W - SOFT_LO;
  localparam int unsigned L15_BIT = LVL_N - 1;

  logic [SOFT_N-1:0] soft_q, soft_d;
  logic              soft_en;
  logic              l15_q, l15_d;
  logic              l15_prev_q;
  logic              tmr_q;
  logic              l15_rise, l15_fall;
  logic              is_set, is_clr;

  assign is_set   = wr_en && (word_sel == SEL_SET);
  assign is_clr   = wr_en && (word_sel == SEL_CLR);
  assign soft_en  = is_set || is_clr;
  assign l15_rise = lvl15_in && !l15_prev_q;
  assign l15_fall = !lvl15_in && l15_prev_q;

  always_comb begin
    soft_d = soft_q;
    if (is_set) soft_d = soft_q | wr_data[WORD_W-1:SOFT_LO];
    if (is_clr) soft_d = soft_q & ~wr_data[WORD_W-1:SOFT_LO];
  end

  // Edge on the broadcast input overrides a software clear in the same cycle.
  always_comb begin
    l15_d = l15_q;
    if (is_clr && wr_data[L15_BIT]) l15_d = 1'b0;
    if (l15_rise)      l15_d = 1'b1;
    else if (l15_fall) l15_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= '0;
    end else if (soft_en) begin
      soft_q <= soft_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l15_q      <= 1'b0;
      l15_prev_q <= 1'b0;
      tmr_q      <= 1'b0;
    end else begin
      l15_q      <= l15_d;
      l15_prev_q <= lvl15_in;
      tmr_q      <= timer_in;
    end
  end

  assign pend_q = {soft_q, 1'b0, l15_q, tmr_q, {(LVL_N-2){1'b0}}};

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import cpu_irq_pkg::*;
#(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned WORD_W = 2 * LVL_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        word_sel,
  input  logic [WORD_W-1:0] pend_q,
  input  logic [LVL_N-1:0]  hard_raw,
  input  logic              is_target,
  output logic [WORD_W-1:0] rd_data
);

  localparam int unsigned HARD_HI = LVL_N - 3;
  localparam int unsigned PAD_W   = WORD_W - HARD_HI - 1;

  logic [HARD_HI-1:0] hard_vis;
  logic [WORD_W-1:0]  view;
  logic [WORD_W-1:0]  rd_d;

  assign hard_vis = is_target ? hard_raw[HARD_HI:1] : '0;
  assign view     = pend_q | {{PAD_W{1'b0}}, hard_vis, 1'b0};

  always_comb begin
    rd_d = '0;
    if (word_sel == SEL_PEND) rd_d = view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned LVL_N = 16,
  parameter int unsigned LVL_W = $clog2(LVL_N)
) (
  input  logic [LVL_N-1:0] vec,
  output logic [LVL_W-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = 1; i < LVL_N; i++) begin
      if (vec[i]) idx = LVL_W'(i);
    end
  end

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned WORD_W = 2 * LVL_N,
  parameter int unsigned LVL_W  = $clog2(LVL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pend_q,
  input  logic [LVL_N-1:0]  hard_req,
  input  logic              master_dis,
  output logic [LVL_N-1:0]  req_lvl,
  output logic [LVL_W-1:0]  irl
);

  localparam int unsigned SOFT_LO = LVL_N + 1;
  localparam int unsigned TMR_BIT = LVL_N - 2;
  localparam int unsigned L15_BIT = LVL_N - 1;

  logic [LVL_N-1:0] soft_lvl;
  logic [LVL_N-1:0] req_d;
  logic [LVL_W-1:0] irl_d;

  assign soft_lvl = {pend_q[WORD_W-1:SOFT_LO], 1'b0};
  assign req_d[0] = 1'b0;

  for (genvar l = 1; l < LVL_N; l++) begin : g_lvl
    if (l == TMR_BIT || l == L15_BIT) begin : g_bypass
      assign req_d[l] = hard_req[l] | soft_lvl[l] | (pend_q[l] & !master_dis);
    end else begin : g_plain
      assign req_d[l] = hard_req[l] | soft_lvl[l];
    end
  end

  irq_prio_enc #(.LVL_N(LVL_N), .LVL_W(LVL_W)) u_enc (
    .vec (req_d),
    .idx (irl_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_lvl <= '0;
      irl     <= '0;
    end else begin
      req_lvl <= req_d;
      irl     <= irl_d;
    end
  end

endmodule

// File: rtl/cpu_irq_slice.sv
module cpu_irq_slice #(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned WORD_W = 2 * LVL_N,
  parameter int unsigned LVL_W  = $clog2(LVL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        word_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              timer_in,
  input  logic              lvl15_in,
  input  logic [LVL_N-1:0]  hard_req,
  input  logic [LVL_N-1:0]  hard_raw,
  input  logic              is_target,
  input  logic              master_dis,
  output logic [LVL_N-1:0]  req_lvl,
  output logic [LVL_W-1:0]  irl
);

  logic [WORD_W-1:0] pend_q;

  irq_pend_regs #(.LVL_N(LVL_N), .WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .word_sel (word_sel),
    .wr_data  (wr_data),
    .timer_in (timer_in),
    .lvl15_in (lvl15_in),
    .pend_q   (pend_q)
  );

  irq_read_port #(.LVL_N(LVL_N), .WORD_W(WORD_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .word_sel  (word_sel),
    .pend_q    (pend_q),
    .hard_raw  (hard_raw),
    .is_target (is_target),
    .rd_data   (rd_data)
  );

  irq_level_merge #(.LVL_N(LVL_N), .WORD_W(WORD_W), .LVL_W(LVL_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_q     (pend_q),
    .hard_req   (hard_req),
    .master_dis (master_dis),
    .req_lvl    (req_lvl),
    .irl        (irl)
  );

endmodule

// File: rtl/cpu_irq_slice_chk.sv
module cpu_irq_slice_chk #(
  parameter int unsigned LVL_N  = 16,
  parameter int unsigned WORD_W = 2 * LVL_N,
  parameter int unsigned LVL_W  = $clog2(LVL_N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        word_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              timer_in,
  input logic              lvl15_in,
  input logic [LVL_N-1:0]  req_lvl,
  input logic [LVL_W-1:0]  irl,
  input logic [WORD_W-1:0] pend_q
);

  localparam int unsigned SOFT_LO = LVL_N + 1;

  assert_rd_other_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && word_sel != 2'd0) |=> (rd_data == '0));

  assert_clr_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_sel == 2'd1) |=>
      ((pend_q[WORD_W-1:SOFT_LO] & $past(wr_data[WORD_W-1:SOFT_LO])) == '0));

  assert_set_soft_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word_sel == 2'd2) |=>
      ((pend_q[WORD_W-1:SOFT_LO] & $past(wr_data[WORD_W-1:SOFT_LO]))
        == $past(wr_data[WORD_W-1:SOFT_LO])));

  assert_timer_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_q[LVL_N-2] == $past(timer_in)));

  assert_l15_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl15_in) |=> pend_q[LVL_N-1]);

  assert_l15_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl15_in) |=> !pend_q[LVL_N-1]);

  assert_lvl0_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_lvl[0]);

  assert_irl_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_lvl == '0) |-> (irl == '0));

  assert_irl_highest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irl != '0) |-> (req_lvl[irl] && ((req_lvl >> irl) == LVL_N'(1))));

endmodule

bind cpu_irq_slice cpu_irq_slice_chk #(.LVL_N(LVL_N), .WORD_W(WORD_W), .LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .word_sel (word_sel),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .timer_in (timer_in),
  .lvl15_in (lvl15_in),
  .req_lvl  (req_lvl),
  .irl      (irl),
  .pend_q   (pend_q)
);

// File: tb/cpu_irq_slice_tb.sv
module cpu_irq_slice_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  word_sel;
  logic        rd_en, wr_en;
  logic [31:0] wr_data, rd_data;
  logic        timer_in, lvl15_in;
  logic [15:0] hard_req, hard_raw;
  logic        is_target, master_dis;
  logic [15:0] req_lvl;
  logic [3:0]  irl;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [31:0] m_pend;
  logic        m_prev;
  logic [31:0] m_rd;
  logic [15:0] m_req;
  logic [3:0]  m_irl;

  cpu_irq_slice u_dut (
    .clk(clk), .rst_n(rst_n), .word_sel(word_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .timer_in(timer_in), .lvl15_in(lvl15_in),
    .hard_req(hard_req), .hard_raw(hard_raw), .is_target(is_target),
    .master_dis(master_dis), .req_lvl(req_lvl), .irl(irl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] f_view(logic [31:0] p, logic [15:0] raw, logic tgt);
    logic [31:0] v;
    v = p;
    if (tgt) v = v | ({16'h0, raw} & 32'h0000_3FFE);
    return v;
  endfunction

  function automatic logic [15:0] f_req(logic [31:0] p, logic [15:0] hr, logic md);
    logic [15:0] r;
    r = hr & 16'hFFFE;
    if (!md) r = r | (p[15:0] & 16'hC000);
    r = r | {p[31:17], 1'b0};
    return r;
  endfunction

  function automatic logic [3:0] f_enc(logic [15:0] v);
    logic [3:0] e;
    e = 4'd0;
    for (int i = 1; i < 16; i++) if (v[i]) e = 4'(i);
    return e;
  endfunction

  function automatic logic [31:0] f_next(logic [31:0] p, logic prev, logic we, logic [1:0] s,
                                         logic [31:0] wd, logic tmr, logic l15);
    logic [31:0] n;
    n = p;
    if (we && s == 2'd2) n = n | (wd & 32'hFFFE_0000);
    if (we && s == 2'd1) n = n & ~(wd & 32'hFFFE_8000);
    n[14] = tmr;
    if (l15 && !prev) n[15] = 1'b1;
    else if (!l15 && prev) n[15] = 1'b0;
    return n;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; word_sel = 2'd3; wr_data = '0;
  endtask

  // one clock: advance model from current inputs, then compare at negedge
  task automatic cyc(string rd_tag);
    logic [31:0] n_rd;
    logic [15:0] n_req;
    logic [31:0] n_pend;
    n_rd   = rd_en ? ((word_sel == 2'd0) ? f_view(m_pend, hard_raw, is_target) : 32'h0) : m_rd;
    n_req  = f_req(m_pend, hard_req, master_dis);
    n_pend = f_next(m_pend, m_prev, wr_en, word_sel, wr_data, timer_in, lvl15_in);
    @(posedge clk);
    @(negedge clk);
    m_rd = n_rd; m_req = n_req; m_irl = f_enc(n_req);
    m_pend = n_pend; m_prev = lvl15_in;
    chk(rd_tag, rd_data, m_rd);
    chk("R8 req_lvl", {16'h0, req_lvl}, {16'h0, m_req});
    chk("R9 irl", {28'h0, irl}, {28'h0, m_irl});
  endtask

  task automatic do_read(string tag);
    rd_en = 1; word_sel = 2'd0; cyc(tag); idle();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; idle(); timer_in = 0; lvl15_in = 0;
    hard_req = '0; hard_raw = '0; is_target = 0; master_dis = 0;
    m_pend = '0; m_prev = 0; m_rd = '0; m_req = '0; m_irl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 req_lvl", {16'h0, req_lvl}, 32'h0);
    chk("R1 irl", {28'h0, irl}, 32'h0);
    do_read("R1 pending");

    // R4: set all software bits, then ignored writes to words 0 and 3
    wr_en = 1; word_sel = 2'd2; wr_data = 32'hFFFF_FFFF; cyc("R4 set"); idle();
    do_read("R4 set readback");
    wr_en = 1; word_sel = 2'd0; wr_data = 32'h0000_0000; cyc("R4 word0 write"); idle();
    wr_en = 1; word_sel = 2'd3; wr_data = 32'h0; cyc("R4 word3 write"); idle();
    do_read("R4 ignored writes");

    // R3: clear half, bit 14 and 16 unaffected
    wr_en = 1; word_sel = 2'd1; wr_data = 32'h5555_7FFF; cyc("R3 clear"); idle();
    do_read("R3 clear readback");

    // R2: other words read zero; no strobe holds
    rd_en = 1; word_sel = 2'd2; cyc("R2 word2 read"); idle();
    do_read("R2 word0 read");
    cyc("R2 hold");

    // R5: timer bit follows input, software cannot clear it
    timer_in = 1; cyc("R5 timer");
    wr_en = 1; word_sel = 2'd1; wr_data = 32'h0000_4000; cyc("R5 clear attempt"); idle();
    do_read("R5 timer readback");

    // R10: master disable hides 14/15 but keeps soft and hard
    lvl15_in = 1; cyc("R6 rise"); cyc("R6 settle");
    master_dis = 1; hard_req = 16'h0104; cyc("R10 masked"); cyc("R10 masked2");
    master_dis = 0; hard_req = '0; cyc("R10 unmasked"); cyc("R10 unmasked2");

    // R6: fall clears; collision rise plus clear keeps set
    lvl15_in = 0; cyc("R6 fall"); do_read("R6 after fall");
    lvl15_in = 1; wr_en = 1; word_sel = 2'd1; wr_data = 32'h0000_8000;
    cyc("R6 collision"); idle(); do_read("R6 collision readback");
    wr_en = 1; word_sel = 2'd1; wr_data = 32'h0000_8000; cyc("R6 sw clear"); idle();
    do_read("R6 sw clear readback");

    // R7: hard view only while target
    hard_raw = 16'hFFFF; is_target = 0; do_read("R7 not target");
    is_target = 1; do_read("R7 target");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      wr_en      = ($urandom % 3) == 0;
      rd_en      = ($urandom % 2) == 0;
      word_sel   = 2'($urandom % 4);
      wr_data    = $urandom;
      if (($urandom % 8) == 0) timer_in = ~timer_in;
      if (($urandom % 6) == 0) lvl15_in = ~lvl15_in;
      hard_req   = (($urandom % 3) == 0) ? 16'($urandom) : 16'h0;
      hard_raw   = 16'($urandom);
      is_target  = ($urandom % 2) == 0;
      master_dis = ($urandom % 4) == 0;
      cyc("R2 random read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule